// File: doc/BRIEF.md
# Timer/Event Counter with Preload

This block is an up-counter with a reload register, driven through a small byte-wide register port. It can time the internal clock through a binary prescaler, count edges of an external signal, or measure the width of a pulse on that signal. When the count passes its all-ones value, the counter takes the reload value and raises a sticky request flag. Software sets the reload value, picks the mode, polarity and division ratio, starts and stops the counter, and reads the count back.

The count is `W` bits wide, either 8 or 16. Byte 0 and byte 1 of the reload value share addresses with the count. Reading the low byte of the count captures the high byte at the same moment, so a later read of address 1 returns a value that matches the low byte. The external input passes through a two-flop synchroniser before any edge or level is used.

Top module: `tmr_evcounter`

## Requirements
- R1: After reset the count, reload value, control byte, request flag, captured high byte and `irq` are all zero.
- R2: Control bits [3:0] hold the division exponent n. Values above 8 act as 8. In timer mode a running counter advances once every 2^n clocks. The prescaler restarts from zero whenever it is idle, so the first advance comes 2^n edges after the run bit is set.
- R3: In every mode, an advance from the all-ones count loads the reload value into the counter and sets the request flag on the same edge.
- R4: Control bit 5 is the run bit. With it clear, or with mode bits [7:6] = 00, the count does not change except through a reload-value write.
- R5: With the run bit clear, a write to address 0 or 1 sets that byte of both the reload value and the counter.
- R6: With the run bit set, a write to address 0 or 1 changes only the reload value. The counter uses the new value at its next overflow.
- R7: Mode 10 counts events. The input goes through two flops. Bit 4 = 0 counts rising edges and bit 4 = 1 counts falling edges. An input change sampled at edge k changes the count at edge k+2.
- R8: Mode 11 measures pulse width. The counter advances on prescaler ticks while the synchronised input is at its active level (bit 4 = 0 for high, 1 for low). The edge that ends the pulse clears the run bit. A control write on the same edge takes precedence.
- R9: The request flag drives `irq`. It stays set until a write to address 3 with bit 0 = 1 clears it. An overflow on the same edge wins over the clear. A write to address 3 with bit 0 = 0 does nothing.
- R10: `rdata` shows the count's low byte at address 0. A read strobe at address 0 captures the count's high byte, and address 1 returns that captured byte.
- R11: Address 2 reads back the control byte. Address 3 reads {7'b0, flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (captures the high byte at address 0) |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ev_in | input | 1 | External event or pulse input, asynchronous |
| irq | output | 1 | Sticky overflow request |

## Verification
The bench builds the counter at its default 16-bit width. This makes the high-byte write, the high-byte capture and the reload of a full 16-bit value observable. Overflow is reached by loading reload values near the top of the range, which needs only a few advances.

The prescaler is built with eight stages. Setting the division exponent to 9 therefore exercises the clamp to 256.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_TIMER = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    // control byte layout: mode[7:6] run[5] pol[4] div[3:0]
    typedef struct packed {
        tmr_mode_e  mode;
        logic       run;
        logic       pol;
        logic [3:0] div;
    } tmr_ctrl_t;

    localparam logic [1:0] ADDR_BYTE0 = 2'd0;
    localparam logic [1:0] ADDR_BYTE1 = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;
    localparam logic [1:0] ADDR_STAT  = 2'd3;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];

    // R7: a detected edge lasts exactly one cycle
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int STAGES = 8,
    parameter int SELW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    logic [STAGES-1:0] cnt_d, cnt_q;
    logic [SELW-1:0]   sel_c;
    logic [STAGES:0]   one_sh;
    logic [STAGES-1:0] mask;

    always_comb begin
        sel_c  = (sel > SELW'(STAGES)) ? SELW'(STAGES) : sel;
        one_sh = (STAGES+1)'(1) << sel_c;
        mask   = STAGES'(one_sh - 1'b1);
        tick   = en && ((cnt_q & mask) == mask);
        cnt_d  = en ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: divide-by-one ticks on every enabled cycle
    a_r2_div_one: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel == '0) |-> tick);
    // R2: with a ratio above one, ticks never fall on consecutive cycles
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0 && en) ##1 (en && $stable(sel)) |-> !tick);

endmodule

// File: rtl/tmr_evcounter.sv
module tmr_evcounter
    import tmr_pkg::*;
#(
    parameter int W        = 16,
    parameter int PRE_BITS = 8,
    parameter int SYNC_FF  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ev_in,
    output logic       irq
);
    localparam int NB = W / 8;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] pre;
        tmr_ctrl_t    ctrl;
        logic         flag;
        logic [7:0]   hi;
    } st_t;

    st_t st_d, st_q;

    logic ev_lvl, ev_rise, ev_fall;
    logic psc_en, tick;
    logic lvl_act, ev_edge, end_edge;
    logic inc_w, ovf_w;
    logic [W-1:0] wr_mask, wr_val;
    logic [15:0]  cnt16;

    tmr_sync_edge #(.STAGES(SYNC_FF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ev_in),
        .level (ev_lvl),
        .rise  (ev_rise),
        .fall  (ev_fall)
    );

    tmr_prescaler #(.STAGES(PRE_BITS), .SELW(4)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (psc_en),
        .sel   (st_q.ctrl.div),
        .tick  (tick)
    );

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_byte
            assign wr_mask[8*b +: 8] = {8{wr_en && (addr == 2'(b))}};
            assign wr_val[8*b +: 8]  = wdata;
        end
    endgenerate

    always_comb begin
        psc_en = st_q.ctrl.run &&
                 (st_q.ctrl.mode == MODE_TIMER || st_q.ctrl.mode == MODE_PULSE);
        lvl_act  = st_q.ctrl.pol ? ~ev_lvl : ev_lvl;
        ev_edge  = st_q.ctrl.pol ? ev_fall : ev_rise;
        end_edge = st_q.ctrl.pol ? ev_rise : ev_fall;
        cnt16    = 16'(st_q.cnt);

        unique case (st_q.ctrl.mode)
            MODE_TIMER: inc_w = st_q.ctrl.run && tick;
            MODE_EVENT: inc_w = st_q.ctrl.run && ev_edge;
            MODE_PULSE: inc_w = st_q.ctrl.run && tick && lvl_act;
            default:    inc_w = 1'b0;
        endcase
        ovf_w = inc_w && (&st_q.cnt);

        st_d = st_q;

        if (ovf_w)      st_d.cnt = st_q.pre;
        else if (inc_w) st_d.cnt = st_q.cnt + 1'b1;
        if (!st_q.ctrl.run)
            st_d.cnt = (st_q.cnt & ~wr_mask) | (wr_val & wr_mask);

        st_d.pre = (st_q.pre & ~wr_mask) | (wr_val & wr_mask);

        if (st_q.ctrl.mode == MODE_PULSE && st_q.ctrl.run && end_edge)
            st_d.ctrl.run = 1'b0;
        if (wr_en && addr == ADDR_CTRL)
            st_d.ctrl = tmr_ctrl_t'(wdata);

        if (wr_en && addr == ADDR_STAT && wdata[0]) st_d.flag = 1'b0;
        if (ovf_w)                                  st_d.flag = 1'b1;

        if (rd_en && addr == ADDR_BYTE0) st_d.hi = cnt16[15:8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            ADDR_BYTE0: rdata = cnt16[7:0];
            ADDR_BYTE1: rdata = st_q.hi;
            ADDR_CTRL:  rdata = st_q.ctrl;
            default:    rdata = {7'b0, st_q.flag};
        endcase
    end

    assign irq = st_q.flag;

    // R3: overflow reloads and raises the request
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_w |=> (st_q.cnt == $past(st_q.pre)) && st_q.flag);
    // R5: stopped counter takes the written low byte
    a_r5_off_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && wr_en && addr == ADDR_BYTE0)
            |=> st_q.cnt[7:0] == $past(wdata));
    // R6: running counter ignores reload-value writes
    a_r6_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.run && wr_en && addr == ADDR_BYTE0 && !inc_w)
            |=> st_q.cnt == $past(st_q.cnt));
    // R4: idle mode never moves the count without a write
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.mode == MODE_IDLE && !wr_en) |=> $stable(st_q.cnt));
    // R8: the end of a pulse stops the counter
    a_r8_autostop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.mode == MODE_PULSE && st_q.ctrl.run && end_edge &&
         !(wr_en && addr == ADDR_CTRL)) |=> !st_q.ctrl.run);
    // R9: request flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(wr_en && addr == ADDR_STAT && wdata[0])) |=> st_q.flag);

endmodule

// File: tb/sim_tmr_evcounter.sv
`timescale 1ns/1ps
module sim_tmr_evcounter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, ev_in = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tmr_evcounter #(.W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ev_in(ev_in), .irq(irq)
    );

    // behavioural reference
    int m_cnt, m_pre, m_ctrl, m_flag, m_hi, m_psc;
    int m_s1, m_s2, m_s3;

    function automatic int model_read(int a);
        case (a)
            0: return m_cnt & 255;
            1: return m_hi;
            2: return m_ctrl;
            default: return m_flag;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_ctrl = 0; m_flag = 0; m_hi = 0;
            m_psc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            int dv, run, mode, pol, psc_en, tick, inc, ovf, endp, edg, act;
            int n_cnt, n_pre, n_ctrl, n_flag, n_hi;
            dv   = ((m_ctrl & 15) > 8) ? 8 : (m_ctrl & 15);
            run  = (m_ctrl >> 5) & 1;
            pol  = (m_ctrl >> 4) & 1;
            mode = (m_ctrl >> 6) & 3;
            psc_en = run && (mode == 1 || mode == 3);
            tick = psc_en && ((m_psc % (1 << dv)) == (1 << dv) - 1);
            edg  = pol ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
            endp = pol ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
            act  = pol ? !m_s2 : m_s2;
            inc  = run && ((mode == 1 && tick) || (mode == 2 && edg) ||
                           (mode == 3 && tick && act));
            ovf  = inc && (m_cnt == 16'hFFFF);
            n_cnt = m_cnt; n_pre = m_pre; n_ctrl = m_ctrl;
            n_flag = m_flag; n_hi = m_hi;
            if (ovf) n_cnt = m_pre;
            else if (inc) n_cnt = m_cnt + 1;
            if (wr_en && addr == 0) begin
                n_pre = (m_pre & 16'hFF00) | wdata;
                if (!run) n_cnt = (m_cnt & 16'hFF00) | wdata;
            end
            if (wr_en && addr == 1) begin
                n_pre = (m_pre & 255) | (int'(wdata) << 8);
                if (!run) n_cnt = (m_cnt & 255) | (int'(wdata) << 8);
            end
            if (mode == 3 && run && endp) n_ctrl = m_ctrl & ~32;
            if (wr_en && addr == 2) n_ctrl = wdata;
            if (wr_en && addr == 3 && wdata[0]) n_flag = 0;
            if (ovf) n_flag = 1;
            if (rd_en && addr == 0) n_hi = (m_cnt >> 8) & 255;
            m_psc = psc_en ? (m_psc + 1) % 256 : 0;
            m_cnt = n_cnt; m_pre = n_pre; m_ctrl = n_ctrl;
            m_flag = n_flag; m_hi = n_hi;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ev_in;
        end
    end

    // every-cycle comparison, labelled with the requirement under test
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(rdata) != model_read(addr) || int'(irq) != m_flag) begin
                fails++;
                $display("FAIL %s addr=%0d rdata=%0h irq=%0d expected rdata=%0h irq=%0d",
                         cur_req, addr, rdata, irq, model_read(addr), m_flag);
            end
        end
    end

    task automatic step(logic w, logic r, logic [1:0] a, logic [7:0] d);
        @(negedge clk); #1;
        wr_en = w; rd_en = r; addr = a; wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        step(1'b1, 1'b0, a, d);
    endtask

    // read strobe, then compare against a fixed expectation
    task automatic expect_rd(logic [1:0] a, logic [7:0] exp, string tag);
        step(1'b0, 1'b1, a, 8'd0);
        #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, rdata, exp);
        end
    endtask

    task automatic expect_irq(logic exp, string tag);
        @(negedge clk); #1;
        wr_en = 0; rd_en = 0;
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%0d expected=%0d", tag, irq, exp);
        end
    endtask

    task automatic pulse_ev(int hi_n, int lo_n);
        @(negedge clk); #1; ev_in = 1'b1;
        idle(hi_n);
        @(negedge clk); #1; ev_in = 1'b0;
        idle(lo_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        expect_rd(2'd0, 8'h00, "R1");
        expect_rd(2'd2, 8'h00, "R1");
        expect_rd(2'd3, 8'h00, "R1");
        expect_irq(1'b0, "R1");

        // R5 stopped counter takes both bytes; R10 high byte capture
        cur_req = "R5";
        wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
        expect_rd(2'd0, 8'hF0, "R5");
        cur_req = "R10";
        expect_rd(2'd1, 8'hFF, "R10");

        // R4 idle mode with run set does not count
        cur_req = "R4";
        wr(2'd2, 8'h20); idle(10);
        expect_rd(2'd0, 8'hF0, "R4");
        // R11 control readback
        cur_req = "R11";
        expect_rd(2'd2, 8'h20, "R11");

        // R3 overflow in timer mode, divide by one
        cur_req = "R3";
        wr(2'd2, 8'h60); idle(20);
        expect_irq(1'b1, "R3");
        // R6 running write leaves counter alone, used at next overflow
        cur_req = "R6";
        wr(2'd0, 8'hF8); idle(30);
        // R9 sticky flag, ignored write, then clear
        cur_req = "R9";
        wr(2'd3, 8'h00); expect_irq(1'b1, "R9");
        wr(2'd2, 8'h40); wr(2'd3, 8'h01);
        expect_irq(1'b0, "R9");
        expect_rd(2'd3, 8'h00, "R9");

        // R2 divide by 8: eight advances in 65 running edges
        cur_req = "R2";
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd2, 8'h63); idle(64); wr(2'd2, 8'h43);
        expect_rd(2'd0, 8'h08, "R2");
        // R2 exponent 9 clamps to 256
        wr(2'd2, 8'h69); idle(600); wr(2'd2, 8'h49);
        idle(2);
        // R4 stopped timer does not count
        cur_req = "R4";
        idle(20);

        // R7 rising edges
        cur_req = "R7";
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd2, 8'hA0);
        for (int i = 0; i < 5; i++) pulse_ev(3, 3);
        expect_rd(2'd0, 8'h05, "R7");
        // R7 falling edges
        wr(2'd2, 8'h80); wr(2'd0, 8'h00);
        wr(2'd2, 8'hB0);
        for (int i = 0; i < 3; i++) pulse_ev(2, 4);
        expect_rd(2'd0, 8'h03, "R7");
        // R3 overflow in event mode
        cur_req = "R3";
        wr(2'd2, 8'h80); wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
        wr(2'd2, 8'hA0);
        for (int i = 0; i < 3; i++) pulse_ev(2, 3);
        expect_irq(1'b1, "R3");
        wr(2'd3, 8'h01);

        // R8 pulse width, active high
        cur_req = "R8";
        wr(2'd2, 8'hC0); wr(2'd0, 8'h00); wr(2'd1, 8'h01);
        wr(2'd2, 8'hE0); idle(4);
        pulse_ev(9, 6);
        expect_rd(2'd2, 8'hC0, "R8");
        expect_rd(2'd0, 8'h0A, "R8");
        // R8 active low
        @(negedge clk); #1; ev_in = 1'b1; idle(4);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'hF0); idle(4);
        @(negedge clk); #1; ev_in = 1'b0; idle(5);
        @(negedge clk); #1; ev_in = 1'b1; idle(6);
        expect_rd(2'd2, 8'hD0, "R8");
        expect_rd(2'd0, 8'h06, "R8");
        idle(4);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule